// File: doc/BRIEF.md
# Lazy-Drain Load-Store Queue

This block is the bookkeeping core of a circular load-store queue. Committed memory operations stay in it: a commit from the reorder buffer only marks the entry removable. The entry keeps its slot, so younger loads can still forward data from it. Slots are reclaimed only when an allocation request for loads or for stores finds its partition at its limit. In that case a small sequencer walks the head of the queue in program order and frees entries one per cycle. It stops as soon as one slot of the requested kind is free. The full indication is then evaluated again, and the allocation goes through.

A removable store at the head must write to the L1 data cache before its slot can be freed. This uses a request/grant handshake, and a refusal ends the drain attempt for that cycle. A removable load at the head can be freed only if it has received its value. A committed load that has no value is a protocol violation. It is reported on a sticky error output, and that load is not removed.

Top module: `lsq_lazy_drain`

## Requirements
- R1: After reset the queue is empty: both occupancy counts are 0, `alloc_idx` is 0, and `alloc_grant`, `st_wr_req` and `drain_err` are low.
- R2: An allocation request whose type count is below its limit is granted in the same cycle. The granted slot index is 0 when the queue is empty, and otherwise the slot after the youngest entry, modulo DEPTH. The count of that type rises by one after the clock edge.
- R3: A commit of an index only marks that entry removable. The occupancy counts do not change, and no cache write is requested.
- R4: `alloc_full` is high while a request's type count equals its limit (`alloc_is_load`=1 selects loads, 0 selects stores), and no grant is given in that case.
- R5: A drain ends without freeing anything when the head entry is not marked removable, so the partition stays full.
- R6: A removable store at the head raises `st_wr_req` with `st_wr_idx` equal to the head slot. It is freed only in a cycle where `st_wr_gnt` is high. A refusal frees nothing, and the drain is retried later.
- R7: A removable load at the head is freed only if it has been marked forwarded. Otherwise `drain_err` goes high and stays high until reset, and the entry stays in the queue.
- R8: A drain frees at most one entry per cycle, strictly from the head. It continues through entries of the other type until one entry of the requested type has been freed.
- R9: Freeing the only remaining entry returns the queue to empty, so the next grant gets index 0. Otherwise the head advances modulo DEPTH, and allocation indices wrap from DEPTH-1 to 0.
- R10: After a drain that frees a slot of the requested type, the still-pending request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocation request, held until granted |
| alloc_is_load | input | 1 | 1 = load entry, 0 = store entry |
| alloc_full | output | 1 | Requested partition is at its limit |
| alloc_grant | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | IDX_W | Slot assigned to the allocation |
| commit_valid | input | 1 | Commit mark strobe |
| commit_idx | input | IDX_W | Slot to mark removable |
| fwd_valid | input | 1 | Load-value-received strobe |
| fwd_idx | input | IDX_W | Load slot that has its value |
| st_wr_req | output | 1 | Store write request to the L1 data cache |
| st_wr_idx | output | IDX_W | Slot of the store being written |
| st_wr_gnt | input | 1 | Cache accepts the write this cycle |
| drain_err | output | 1 | Sticky: committed load without a value reached the head |
| ld_cnt | output | CNT_W | Resident load entries |
| st_cnt | output | CNT_W | Resident store entries |

## Verification
If a head pointer goes wrong, the cache sees the wrong store: `st_wr_idx` shows a slot other than the oldest committed store on the first drain that reaches it. It also shows in the next grant index, which comes out a slot off. If a per-type counter goes wrong, `alloc_full` asserts early or late. This is visible on the first request of that type after the error, and the counts on `ld_cnt`/`st_cnt` stop matching the allocations minus the drained entries. If a removal is ordered wrongly or one is lost, the queue fails to grant after a drain that should have freed the requested type.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    typedef struct packed {
        logic used;     // slot holds a resident entry
        logic is_load;  // 1 = load, 0 = store
        logic can_rm;   // committed, may be drained
        logic fwd;      // load has received its value
    } lsq_ent_t;

    typedef enum logic [1:0] {
        DR_IDLE = 2'd0,
        DR_RUN  = 2'd1,
        DR_DONE = 2'd2
    } drain_st_t;

endpackage

// File: rtl/lsq_entry_bank.sv
module lsq_entry_bank
    import lsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_do,
    input  logic             alloc_is_load,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             commit_valid,
    input  logic [IDX_W-1:0] commit_idx,
    input  logic             fwd_valid,
    input  logic [IDX_W-1:0] fwd_idx,
    input  logic             rm_head,
    input  logic [IDX_W-1:0] head_idx,
    output lsq_ent_t         head_ent
);

    lsq_ent_t ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        lsq_ent_t e_d, e_q;

        always_comb begin
            e_d = e_q;
            if (commit_valid && commit_idx == IDX_W'(g) && e_q.used)
                e_d.can_rm = 1'b1;
            if (fwd_valid && fwd_idx == IDX_W'(g) && e_q.used && e_q.is_load)
                e_d.fwd = 1'b1;
            if (rm_head && head_idx == IDX_W'(g))
                e_d = '0;
            if (alloc_do && alloc_idx == IDX_W'(g)) begin
                e_d.used    = 1'b1;
                e_d.is_load = alloc_is_load;
                e_d.can_rm  = 1'b0;
                e_d.fwd     = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) e_q <= '0;
            else        e_q <= e_d;
        end

        assign ent_q[g] = e_q;

        // R2: a fresh allocation is never already removable
        a_r2_alloc_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_do && alloc_idx == IDX_W'(g)) |=> (e_q.used && !e_q.can_rm));
    end

    assign head_ent = ent_q[head_idx];

    // R2: allocation never lands on a resident entry
    a_r2_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_do |-> !ent_q[alloc_idx].used);

endmodule

// File: rtl/lsq_ptr_ctrl.sv
module lsq_ptr_ctrl #(
    parameter int DEPTH    = 8,
    parameter int LD_LIMIT = 4,
    parameter int ST_LIMIT = 4,
    parameter int IDX_W    = $clog2(DEPTH),
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_do,
    input  logic             alloc_is_load,
    input  logic             rm_head,
    input  logic             rm_is_load,
    output logic [IDX_W-1:0] head_idx,
    output logic             q_empty,
    output logic [IDX_W-1:0] alloc_idx,
    output logic [CNT_W-1:0] ld_cnt,
    output logic [CNT_W-1:0] st_cnt
);

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic             empty;
        logic [CNT_W-1:0] ld;
        logic [CNT_W-1:0] st;
    } ptr_t;

    ptr_t p_d, p_q;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
    endfunction

    always_comb begin
        p_d = p_q;
        if (alloc_do) begin
            if (p_q.empty) begin
                p_d.head  = '0;
                p_d.tail  = '0;
                p_d.empty = 1'b0;
            end else begin
                p_d.tail = step(p_q.tail);
            end
            if (alloc_is_load) p_d.ld = p_q.ld + 1'b1;
            else               p_d.st = p_q.st + 1'b1;
        end else if (rm_head) begin
            if (p_q.head == p_q.tail) begin
                p_d.head  = '0;
                p_d.tail  = '0;
                p_d.empty = 1'b1;
            end else begin
                p_d.head = step(p_q.head);
            end
            if (rm_is_load) p_d.ld = p_q.ld - 1'b1;
            else            p_d.st = p_q.st - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '{head: '0, tail: '0, empty: 1'b1, ld: '0, st: '0};
        else        p_q <= p_d;
    end

    assign head_idx  = p_q.head;
    assign q_empty   = p_q.empty;
    assign alloc_idx = p_q.empty ? '0 : step(p_q.tail);
    assign ld_cnt    = p_q.ld;
    assign st_cnt    = p_q.st;

    // R4: partitions never exceed their limits
    a_r4_cnt_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_cnt <= CNT_W'(LD_LIMIT)) && (st_cnt <= CNT_W'(ST_LIMIT)));

    // R8: allocation and removal never coincide
    a_r8_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_do && rm_head));

    // R9: an empty queue holds no entries
    a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> (ld_cnt == '0 && st_cnt == '0));

    // R9: removing the single resident entry empties the queue
    a_r9_last_rm: assert property (@(posedge clk) disable iff (!rst_n)
        (rm_head && !q_empty && (ld_cnt + st_cnt) == CNT_W'(1)) |=> q_empty);

endmodule

// File: rtl/lsq_drain_seq.sv
module lsq_drain_seq
    import lsq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     want_load,
    input  logic     head_valid,
    input  lsq_ent_t head_ent,
    input  logic     st_wr_gnt,
    output logic     rm_head,
    output logic     rm_is_load,
    output logic     st_wr_req,
    output logic     busy,
    output logic     drain_err
);

    typedef struct packed {
        drain_st_t st;
        logic      want_load;
        logic      err;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        rm_head   = 1'b0;
        st_wr_req = 1'b0;
        unique case (s_q.st)
            DR_IDLE: begin
                if (start) begin
                    s_d.st        = DR_RUN;
                    s_d.want_load = want_load;
                end
            end
            DR_RUN: begin
                if (!head_valid || !head_ent.can_rm) begin
                    s_d.st = DR_DONE;
                end else if (!head_ent.is_load) begin
                    st_wr_req = 1'b1;
                    if (st_wr_gnt) begin
                        rm_head = 1'b1;
                        if (!s_q.want_load) s_d.st = DR_DONE;
                    end else begin
                        s_d.st = DR_DONE;
                    end
                end else if (head_ent.fwd) begin
                    rm_head = 1'b1;
                    if (s_q.want_load) s_d.st = DR_DONE;
                end else begin
                    s_d.err = 1'b1;
                    s_d.st  = DR_DONE;
                end
            end
            DR_DONE: s_d.st = DR_IDLE;
            default: s_d.st = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: DR_IDLE, want_load: 1'b0, err: 1'b0};
        else        s_q <= s_d;
    end

    assign rm_is_load = head_ent.is_load;
    assign busy       = (s_q.st == DR_RUN);
    assign drain_err  = s_q.err;

    // R5: nothing leaves the queue unless it was committed
    a_r5_rm_committed: assert property (@(posedge clk) disable iff (!rst_n)
        rm_head |-> (head_ent.used && head_ent.can_rm));

    // R6: a write request always names a committed resident store
    a_r6_req_store: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_req |-> (head_ent.used && !head_ent.is_load && head_ent.can_rm));

    // R7: a load leaves only with its value
    a_r7_load_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (rm_head && head_ent.is_load) |-> head_ent.fwd);

    // R7: the error flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        drain_err |=> drain_err);

endmodule

// File: rtl/lsq_lazy_drain.sv
module lsq_lazy_drain
    import lsq_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int LD_LIMIT = 4,
    parameter int ST_LIMIT = 4,
    parameter int IDX_W    = $clog2(DEPTH),
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             alloc_is_load,
    output logic             alloc_full,
    output logic             alloc_grant,
    output logic [IDX_W-1:0] alloc_idx,
    input  logic             commit_valid,
    input  logic [IDX_W-1:0] commit_idx,
    input  logic             fwd_valid,
    input  logic [IDX_W-1:0] fwd_idx,
    output logic             st_wr_req,
    output logic [IDX_W-1:0] st_wr_idx,
    input  logic             st_wr_gnt,
    output logic             drain_err,
    output logic [CNT_W-1:0] ld_cnt,
    output logic [CNT_W-1:0] st_cnt
);

    logic             type_full;
    logic             rm_head, rm_is_load, busy, q_empty;
    logic [IDX_W-1:0] head_idx;
    lsq_ent_t         head_ent;

    assign type_full   = alloc_is_load ? (ld_cnt == CNT_W'(LD_LIMIT))
                                       : (st_cnt == CNT_W'(ST_LIMIT));
    assign alloc_full  = alloc_req && type_full;
    assign alloc_grant = alloc_req && !type_full && !busy;
    assign st_wr_idx   = head_idx;

    lsq_ptr_ctrl #(
        .DEPTH(DEPTH), .LD_LIMIT(LD_LIMIT), .ST_LIMIT(ST_LIMIT),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .alloc_do(alloc_grant), .alloc_is_load(alloc_is_load),
        .rm_head(rm_head), .rm_is_load(rm_is_load),
        .head_idx(head_idx), .q_empty(q_empty), .alloc_idx(alloc_idx),
        .ld_cnt(ld_cnt), .st_cnt(st_cnt)
    );

    lsq_entry_bank #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .alloc_do(alloc_grant), .alloc_is_load(alloc_is_load), .alloc_idx(alloc_idx),
        .commit_valid(commit_valid), .commit_idx(commit_idx),
        .fwd_valid(fwd_valid), .fwd_idx(fwd_idx),
        .rm_head(rm_head), .head_idx(head_idx), .head_ent(head_ent)
    );

    lsq_drain_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(alloc_full), .want_load(alloc_is_load),
        .head_valid(!q_empty), .head_ent(head_ent), .st_wr_gnt(st_wr_gnt),
        .rm_head(rm_head), .rm_is_load(rm_is_load), .st_wr_req(st_wr_req),
        .busy(busy), .drain_err(drain_err)
    );

    // R4: no grant into a full partition
    a_r4_no_grant_full: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_full |-> !alloc_grant);

    // R3: commit marks alone leave the occupancy untouched
    a_r3_commit_keeps_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !alloc_grant && !rm_head) |=> ($stable(ld_cnt) && $stable(st_cnt)));

    // R6: a refused write frees nothing
    a_r6_refused_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_req && !st_wr_gnt) |=> $stable(st_cnt));

endmodule

// File: tb/sim_lsq_lazy_drain.sv
module sim_lsq_lazy_drain;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // main instance: DEPTH 8, 4 loads, 4 stores
    logic       a_req = 0, a_ld = 0, a_full, a_gnt;
    logic [2:0] a_idx;
    logic       c_v = 0, f_v = 0, w_gnt = 0, w_req, err;
    logic [2:0] c_i = 0, f_i = 0, w_idx;
    logic [3:0] ldc, stc;

    lsq_lazy_drain #(.DEPTH(8), .LD_LIMIT(4), .ST_LIMIT(4)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(a_req), .alloc_is_load(a_ld), .alloc_full(a_full),
        .alloc_grant(a_gnt), .alloc_idx(a_idx),
        .commit_valid(c_v), .commit_idx(c_i), .fwd_valid(f_v), .fwd_idx(f_i),
        .st_wr_req(w_req), .st_wr_idx(w_idx), .st_wr_gnt(w_gnt),
        .drain_err(err), .ld_cnt(ldc), .st_cnt(stc)
    );

    // small instance: DEPTH 4, one load, one store
    logic       b_req = 0, b_ld = 0, b_full, b_gnt, b_cv = 0, b_fv = 0, b_wreq, b_err;
    logic [1:0] b_idx, b_ci = 0, b_fi = 0, b_widx;
    logic [2:0] b_ldc, b_stc;

    lsq_lazy_drain #(.DEPTH(4), .LD_LIMIT(1), .ST_LIMIT(1)) u1 (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(b_req), .alloc_is_load(b_ld), .alloc_full(b_full),
        .alloc_grant(b_gnt), .alloc_idx(b_idx),
        .commit_valid(b_cv), .commit_idx(b_ci), .fwd_valid(b_fv), .fwd_idx(b_fi),
        .st_wr_req(b_wreq), .st_wr_idx(b_widx), .st_wr_gnt(1'b0),
        .drain_err(b_err), .ld_cnt(b_ldc), .st_cnt(b_stc)
    );

    int n_chk = 0;
    int n_bad = 0;

    // {is_load, expected slot}
    localparam logic [3:0] FILL_VEC [8] = '{
        4'b1_000, 4'b0_001, 4'b1_010, 4'b0_011,
        4'b1_100, 4'b0_101, 4'b1_110, 4'b0_111
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic alloc0(input logic is_ld, output logic [2:0] idx, output logic ok);
        ok = 1'b0;
        idx = '0;
        @(negedge clk);
        a_req = 1'b1;
        a_ld  = is_ld;
        for (int i = 0; i < 60; i++) begin
            #1;
            if (a_gnt) begin ok = 1'b1; idx = a_idx; end
            @(negedge clk);
            if (ok) break;
        end
        a_req = 1'b0;
    endtask

    task automatic commit0(input logic [2:0] i);
        @(negedge clk); c_v = 1'b1; c_i = i;
        @(negedge clk); c_v = 1'b0;
    endtask

    task automatic fwd0(input logic [2:0] i);
        @(negedge clk); f_v = 1'b1; f_i = i;
        @(negedge clk); f_v = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run completion)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2:0] idx;
        logic ok;
        logic seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 ld_cnt", int'(ldc), 0);
        check("R1 st_cnt", int'(stc), 0);
        check("R1 alloc_idx", int'(a_idx), 0);
        check("R1 grant", int'(a_gnt), 0);
        check("R1 st_wr_req", int'(w_req), 0);
        check("R1 drain_err", int'(err), 0);

        // R2: fill from the vector table
        for (int k = 0; k < 8; k++) begin
            alloc0(FILL_VEC[k][3], idx, ok);
            check("R2 granted", int'(ok), 1);
            check("R2 slot", int'(idx), int'(FILL_VEC[k][2:0]));
        end
        check("R2 ld_cnt", int'(ldc), 4);
        check("R2 st_cnt", int'(stc), 4);

        // R4/R5: full, nothing committed, nothing drains
        @(negedge clk); a_req = 1'b1; a_ld = 1'b1;
        #1;
        check("R4 alloc_full", int'(a_full), 1);
        check("R4 no grant", int'(a_gnt), 0);
        repeat (6) @(negedge clk);
        #1;
        check("R5 no grant", int'(a_gnt), 0);
        check("R5 ld_cnt", int'(ldc), 4);
        check("R5 st_wr_req", int'(w_req), 0);
        @(negedge clk); a_req = 1'b0;

        // R3: commits keep the entries resident
        for (int k = 0; k < 4; k++) commit0(3'(k));
        #1;
        check("R3 ld_cnt", int'(ldc), 4);
        check("R3 st_cnt", int'(stc), 4);
        check("R3 st_wr_req", int'(w_req), 0);
        fwd0(3'd0);
        fwd0(3'd2);

        // R6/R8: store request drains load 0, then waits on store 1
        @(negedge clk); a_req = 1'b1; a_ld = 1'b0; w_gnt = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (w_req) begin seen = 1'b1; break; end
        end
        check("R6 st_wr_req seen", int'(seen), 1);
        check("R6 st_wr_idx", int'(w_idx), 1);
        check("R8 load freed first", int'(ldc), 3);
        repeat (6) @(negedge clk);
        #1;
        check("R6 refused keeps store", int'(stc), 4);
        check("R6 no grant while refused", int'(a_gnt), 0);
        @(negedge clk); w_gnt = 1'b1;
        ok = 1'b0;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (a_gnt) begin ok = 1'b1; idx = a_idx; end
            @(negedge clk);
            if (ok) break;
        end
        a_req = 1'b0; w_gnt = 1'b0;
        check("R10 granted after drain", int'(ok), 1);
        check("R9 slot wraps", int'(idx), 0);
        check("R8 st_cnt", int'(stc), 4);
        check("R8 ld_cnt", int'(ldc), 3);

        alloc0(1'b1, idx, ok);
        check("R2 slot after wrap", int'(idx), 1);
        check("R2 ld_cnt", int'(ldc), 4);
        alloc0(1'b1, idx, ok);
        check("R10 granted", int'(ok), 1);
        check("R10 slot", int'(idx), 2);
        check("R10 ld_cnt", int'(ldc), 4);

        // R9: small instance, last entry removal empties the queue
        @(negedge clk); b_req = 1'b1; b_ld = 1'b1;
        #1;
        check("R2 small grant", int'(b_gnt), 1);
        check("R2 small slot", int'(b_idx), 0);
        @(negedge clk); b_req = 1'b0;
        b_cv = 1'b1; b_ci = 2'd0; b_fv = 1'b1; b_fi = 2'd0;
        @(negedge clk); b_cv = 1'b0; b_fv = 1'b0;
        b_req = 1'b1; b_ld = 1'b1;
        ok = 1'b0;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (b_gnt) begin ok = 1'b1; idx = 3'(b_idx); end
            @(negedge clk);
            if (ok) break;
        end
        b_req = 1'b0;
        check("R9 small granted", int'(ok), 1);
        check("R9 empty marker slot", int'(idx), 0);
        check("R9 small ld_cnt", int'(b_ldc), 1);

        // R7: committed load with no value at the head
        b_cv = 1'b1; b_ci = 2'd0;
        @(negedge clk); b_cv = 1'b0;
        b_req = 1'b1; b_ld = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        check("R7 drain_err", int'(b_err), 1);
        check("R7 load kept", int'(b_ldc), 1);
        check("R7 no grant", int'(b_gnt), 0);
        @(negedge clk); b_req = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R7 error sticky", int'(b_err), 1);
        check("R7 main no error", int'(err), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule